// File: doc/BRIEF.md
# Synchronizable Programmable Clock Divider

This block divides its input clock by an integer ratio from 1 to 8. It gives two outputs. The first is a one-cycle divided-clock enable for logic that stays in the input clock domain. The second is a registered divided clock level. Software-side control arrives as a write strobe with a 5-bit data word. That word sets the ratio, turns SYNC realignment on or off, and selects between realigning on every SYNC and realigning once per write.

The SYNC input is asynchronous. The block synchronizes it into the input clock domain, and only its rising edge counts. When realignment is enabled, a SYNC event restarts the divider counter and the output level. Several devices that share one SYNC line then produce their enable pulses on the same input edge. In one-shot mode, a control write arms the block. The first qualifying SYNC after that write is used and sets a sticky consumed flag. Any later SYNC is ignored until the next write.

A new ratio never cuts a divided period short. It is held pending and loaded when the counter wraps or when a SYNC restarts the counter, whichever comes first.

Top module: `clk_div_sync`

## Requirements
- R1: The control word holds the ratio minus 1 in bits [2:0], so ratio N is written as N-1. Once loaded, div_en_o is high for exactly one input cycle in every N cycles. For N = 1 it is high in every cycle.
- R2: After each enable pulse, div_clk_o is high for the first floor(N/2) cycles of the next period and low for the rest. For N = 1 it stays low.
- R3: After reset, the active ratio is 1, realignment is off, one-shot mode is off, div_clk_o is low, sync_done_o is low and div_en_o is high.
- R4: sync_i passes through two flip-flops before use, and only its rising edge is an event. Holding sync_i high, or letting it fall, leaves the divider phase unchanged.
- R5: When bit 3 of the control word (realignment enable) is 0, a SYNC event has no effect on either output.
- R6: Bit 3 is 1 and bit 4 (one-shot) is 0. If sync_i is first sampled high at clock edge k, then div_en_o is low in the cycle after edge k+1. The counter restarts at edge k+2 with the pending ratio. The first enable pulse follows edge k+N+1. Every such event realigns the divider.
- R7: Bit 3 and bit 4 are both 1. Only the first SYNC event after a control write realigns the divider. Later events leave the phase unchanged.
- R8: sync_done_o goes high on the edge where an armed one-shot SYNC is used. It stays high until the next control write, which clears it.
- R9: A written ratio takes effect only at the next counter wrap or at the next accepted SYNC restart, so the period in progress completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Asynchronous alignment request |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 5 | Control word: [2:0] ratio-1, [3] realign enable, [4] one-shot |
| div_en_o | output | 1 | One-cycle enable at each divided period |
| div_clk_o | output | 1 | Registered divided clock level |
| sync_done_o | output | 1 | Sticky flag: armed one-shot SYNC consumed |

## Verification
A wrong counter or active-ratio value shows at the ports within one divided period. It appears as an enable pulse on the wrong cycle or a level step at the wrong point, so at most eight input cycles after the fault. A wrong arming or consumed-flag state shows on the next SYNC event. Either the phase fails to realign on the cycle given in R6, or sync_done_o holds the wrong value two edges after the synchronized edge. The bench tracks the expected phase on every cycle across all stimulus, so any phase slip is reported in the cycle where it occurs.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  parameter int RATIO_W = 3;

  typedef struct packed {
    logic               one_shot;
    logic               sync_en;
    logic [RATIO_W-1:0] ratio_m1;
  } div_cfg_t;

  localparam int CFG_W = $bits(div_cfg_t);
endpackage

// File: rtl/clk_div_sync_edge.sv
module clk_div_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], sync_i};
  end

  // last synchronizer stage against its delayed copy
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/clk_div_cfg.sv
module clk_div_cfg
  import clk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             sync_rise_i,
  output div_cfg_t         cfg_o,
  output logic             sync_go_o,
  output logic             done_o
);
  div_cfg_t cfg_q;
  logic     armed_q, done_q, consume;

  assign consume   = sync_rise_i & cfg_q.sync_en & cfg_q.one_shot & armed_q;
  assign sync_go_o = sync_rise_i & cfg_q.sync_en & (~cfg_q.one_shot | armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (we_i) begin
      cfg_q   <= div_cfg_t'(wdata_i);
      armed_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (consume) begin
      armed_q <= 1'b0;
      done_q  <= 1'b1;
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = done_q;
endmodule

// File: rtl/clk_div_core.sv
module clk_div_core
  import clk_div_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               sync_go_i,
  output logic               en_o,
  output logic               clk_o,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam int HW = RATIO_W + 1;

  logic [RATIO_W-1:0] cnt_q, cnt_d, ratio_q, ratio_d;
  logic [HW-1:0]      half_d;
  logic               clk_q, clk_d, wrap, load;

  assign wrap = (cnt_q == ratio_q);
  assign load = wrap | sync_go_i;

  always_comb begin
    cnt_d   = load ? '0 : cnt_q + 1'b1;
    ratio_d = load ? ratio_i : ratio_q;
    half_d  = ({1'b0, ratio_d} + HW'(1)) >> 1;
    clk_d   = ({1'b0, cnt_d} < half_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      clk_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      clk_q   <= clk_d;
    end
  end

  // no pulse in the cycle a restart is taken
  assign en_o    = wrap & ~sync_go_i;
  assign clk_o   = clk_q;
  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/clk_div_sync.sv
module clk_div_sync
  import clk_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             div_en_o,
  output logic             div_clk_o,
  output logic             sync_done_o
);
  div_cfg_t           cfg;
  logic               sync_rise, sync_go;
  logic [RATIO_W-1:0] cnt_q, ratio_act;

  clk_div_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .rise_o (sync_rise)
  );

  clk_div_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .sync_rise_i (sync_rise),
    .cfg_o       (cfg),
    .sync_go_o   (sync_go),
    .done_o      (sync_done_o)
  );

  clk_div_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ratio_i   (cfg.ratio_m1),
    .sync_go_i (sync_go),
    .en_o      (div_en_o),
    .clk_o     (div_clk_o),
    .cnt_o     (cnt_q),
    .ratio_o   (ratio_act)
  );
endmodule

// File: rtl/clk_div_sync_chk.sv
module clk_div_sync_chk
  import clk_div_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic               div_en_o,
  input logic               div_clk_o,
  input logic               sync_done_o,
  input logic [RATIO_W-1:0] cnt_q,
  input logic [RATIO_W-1:0] ratio_act
);
  AST_EN_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en_o |=> (cnt_q == '0)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ratio_act); // R1
  AST_LEVEL_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_clk_o |-> (ratio_act != '0)); // R2
  AST_DONE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_done_o) |-> (cnt_q == '0)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_done_o && !cfg_we_i) |=> sync_done_o); // R8
  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !sync_done_o); // R8
  AST_RATIO_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_act) |-> (cnt_q == '0)); // R9
endmodule

bind clk_div_sync clk_div_sync_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .div_en_o    (div_en_o),
  .div_clk_o   (div_clk_o),
  .sync_done_o (sync_done_o),
  .cnt_q       (cnt_q),
  .ratio_act   (ratio_act)
);

// File: tb/clk_div_sync_bench.sv
module clk_div_sync_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [4:0] cfg_wdata_i = '0;
  logic       div_en_o, div_clk_o, sync_done_o;

  int n_chk = 0, n_fail = 0;
  int ph = 0, cur_n = 1, pend_n = 1;
  bit sup = 0;

  always #4 clk = ~clk;

  clk_div_sync u_clk_div_sync (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .div_en_o    (div_en_o),
    .div_clk_o   (div_clk_o),
    .sync_done_o (sync_done_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one sample at the falling edge, then advance the phase model
  task automatic cyc(string req);
    bit e_en, e_clk;
    @(negedge clk);
    e_en  = (ph == cur_n - 1) && !sup;
    e_clk = ph < cur_n / 2;
    chk(div_en_o == e_en, req, "div_en_o", div_en_o, e_en);
    chk(div_clk_o == e_clk, req, "div_clk_o", div_clk_o, e_clk);
    if (sup) begin
      ph = 0; cur_n = pend_n; sup = 0;
    end else if (ph == cur_n - 1) begin
      ph = 0; cur_n = pend_n;
    end else ph++;
  endtask

  task automatic run(int k, string req);
    repeat (k) cyc(req);
  endtask

  task automatic write_cfg(bit os, bit se, int n, string req);
    cfg_we_i = 1'b1;
    cfg_wdata_i = {os, se, 3'(n - 1)};
    pend_n = n;
    cyc(req);
    cfg_we_i = 1'b0;
  endtask

  task automatic sync_rise(bit take, string req);
    sync_i = 1'b1;
    cyc(req);
    if (take) sup = 1;
    cyc(req);
  endtask

  task automatic sync_fall(string req);
    sync_i = 1'b0;
    run(3, req);
  endtask

  task automatic t_reset;
    cyc("R3");
    chk(sync_done_o == 1'b0, "R3", "sync_done_o", sync_done_o, 0);
    run(3, "R3");
  endtask

  task automatic t_ratios;
    for (int n = 1; n <= 8; n++) begin
      write_cfg(1'b0, 1'b1, n, "R6");
      sync_rise(1'b1, "R6");
      run(2 * n + 1, "R1 R2");
      sync_fall("R4");
      run(n + 2, "R4");
    end
  endtask

  task automatic t_ratio_change;
    write_cfg(1'b0, 1'b1, 8, "R9");
    sync_rise(1'b1, "R9");
    sync_fall("R9");
    write_cfg(1'b0, 1'b1, 2, "R9");
    run(14, "R9");
    write_cfg(1'b0, 1'b1, 5, "R9");
    sync_rise(1'b1, "R9");
    run(12, "R9");
    sync_fall("R9");
  endtask

  task automatic t_disabled;
    write_cfg(1'b0, 1'b0, 4, "R5");
    run(8, "R5");
    sync_rise(1'b0, "R5");
    run(6, "R5");
    sync_fall("R5");
    run(5, "R5");
  endtask

  task automatic t_one_shot;
    write_cfg(1'b1, 1'b1, 3, "R7");
    chk(sync_done_o == 1'b0, "R8", "sync_done_o", sync_done_o, 0);
    sync_rise(1'b1, "R7");
    cyc("R7");
    chk(sync_done_o == 1'b1, "R8", "sync_done_o", sync_done_o, 1);
    sync_fall("R7");
    run(1, "R7");
    sync_rise(1'b0, "R7");
    run(5, "R7");
    chk(sync_done_o == 1'b1, "R8", "sync_done_o", sync_done_o, 1);
    sync_fall("R7");
    write_cfg(1'b1, 1'b1, 3, "R8");
    chk(sync_done_o == 1'b0, "R8", "sync_done_o", sync_done_o, 0);
    sync_rise(1'b1, "R7");
    run(7, "R7");
    chk(sync_done_o == 1'b1, "R8", "sync_done_o", sync_done_o, 1);
    sync_fall("R7");
  endtask

  task automatic t_repeat_sync;
    write_cfg(1'b0, 1'b1, 6, "R6");
    sync_rise(1'b1, "R6");
    sync_fall("R6");
    sync_rise(1'b1, "R6");
    run(9, "R6");
    sync_fall("R6");
    sync_rise(1'b1, "R6");
    run(13, "R6");
    sync_fall("R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_ratios();
    t_ratio_change();
    t_disabled();
    t_one_shot();
    t_repeat_sync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule